// File: doc/BRIEF.md
# Vector Element Step Sequencer

This block keeps the position of a vector instruction loop. It holds a source pair (an element step and a sub-element step) and a destination pair of the same shape. A single-cycle advance strobe moves both pairs forward in the same clock. The end-of-source and end-of-destination flags come from outside the block. The sub-vector length input sets where the sub-element counters stop.

Each pair has its own nesting control. When the control is clear, the sub-element counter is the inner loop and the element counter is the outer loop. When the control is set, the order is inverted, so the element counter runs inside and the sub-element counter runs outside. The pack bit governs the source pair and the unpack bit governs the destination pair. A load port writes all four counters at once, so that the loop state can be restored after a context switch.

Top module: `vec_step_seq`

## Requirements
- R1: A synchronous reset sets all four counters to 0 on the next clock edge, whatever the other inputs are.
- R2: When neither advance nor load is asserted, all four counters hold their values, even while pack, unpack, the end flags and the length change.
- R3: Load writes the four load values into the counters on the next edge. Load has priority over advance, and reset has priority over load.
- R4: On advance with pack clear, a source sub-step that is not equal to the sub-vector length increments by 1, and the source step holds.
- R5: On advance with pack clear, a source sub-step equal to the length resets to 0. If the source end flag is clear, the source step increments by 1.
- R6: On advance with pack clear, a source sub-step equal to the length resets to 0. If the source end flag is set, the source step holds.
- R7: On advance with pack set and the source end flag clear, the source step increments by 1 and the source sub-step holds.
- R8: On advance with pack set and the source end flag set, the source step resets to 0. If the source sub-step is not equal to the length, it increments by 1.
- R9: On advance with pack set, the source end flag set and the source sub-step equal to the length, the source step resets to 0 and the sub-step holds.
- R10: The destination pair follows R4 to R9, with unpack in place of pack and the destination end flag in place of the source end flag. It updates independently of the source pair and the source controls do not affect it.
- R11: The element steps are 7 bits wide and the sub-element steps are 2 bits wide. An increment from the maximum value wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv | input | 1 | Single-cycle advance strobe |
| ld | input | 1 | Load all four counters |
| ld_src_step | input | 7 | Load value for the source step |
| ld_src_sub | input | 2 | Load value for the source sub-step |
| ld_dst_step | input | 7 | Load value for the destination step |
| ld_dst_sub | input | 2 | Load value for the destination sub-step |
| sub_len | input | 2 | Sub-vector length (the sub-step end value) |
| pack | input | 1 | Inverts the nesting of the source pair |
| unpack | input | 1 | Inverts the nesting of the destination pair |
| src_end | input | 1 | End-of-source flag |
| dst_end | input | 1 | End-of-destination flag |
| src_step | output | 7 | Source element step |
| src_sub | output | 2 | Source sub-element step |
| dst_step | output | 7 | Destination element step |
| dst_sub | output | 2 | Destination sub-element step |

## Verification
All four counters are registered outputs, so a wrong next-state choice shows at the ports one clock after the advance that caused it. A swapped nesting order shows as the wrong counter moving. A missed end test shows as a sub-step that walks past the length, or as a step that does not return to 0. Because the pairs are independent, the bench drives different controls on the source and destination pairs in the same cycle. A leak from one pair into the other then appears in that same cycle's result.

// File: rtl/vec_step_seq.sv
module vec_step_seq #(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              ld,
  input  logic [STEP_W-1:0] ld_src_step,
  input  logic [SUB_W-1:0]  ld_src_sub,
  input  logic [STEP_W-1:0] ld_dst_step,
  input  logic [SUB_W-1:0]  ld_dst_sub,
  input  logic [SUB_W-1:0]  sub_len,
  input  logic              pack,
  input  logic              unpack,
  input  logic              src_end,
  input  logic              dst_end,
  output logic [STEP_W-1:0] src_step,
  output logic [SUB_W-1:0]  src_sub,
  output logic [STEP_W-1:0] dst_step,
  output logic [SUB_W-1:0]  dst_sub
);
  localparam int PAIR_W = STEP_W + SUB_W;

  function automatic logic [PAIR_W-1:0] pair_next(
    input logic [STEP_W-1:0] step,
    input logic [SUB_W-1:0]  sub,
    input logic [SUB_W-1:0]  len,
    input logic              inv,
    input logic              fin
  );
    logic [STEP_W-1:0] ns;
    logic [SUB_W-1:0]  nb;
    logic              sub_done;
    sub_done = (sub == len);
    ns = step;
    nb = sub;
    if (inv) begin
      if (fin) begin
        ns = '0;
        if (!sub_done) nb = sub + 1'b1;
      end else begin
        ns = step + 1'b1;
      end
    end else begin
      if (sub_done) begin
        nb = '0;
        if (!fin) ns = step + 1'b1;
      end else begin
        nb = sub + 1'b1;
      end
    end
    return {ns, nb};
  endfunction

  logic [PAIR_W-1:0] src_nxt, dst_nxt;

  assign src_nxt = pair_next(src_step, src_sub, sub_len, pack,   src_end);
  assign dst_nxt = pair_next(dst_step, dst_sub, sub_len, unpack, dst_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_step <= '0;
      src_sub  <= '0;
      dst_step <= '0;
      dst_sub  <= '0;
    end else if (ld) begin
      src_step <= ld_src_step;
      src_sub  <= ld_src_sub;
      dst_step <= ld_dst_step;
      dst_sub  <= ld_dst_sub;
    end else if (adv) begin
      {src_step, src_sub} <= src_nxt;
      {dst_step, dst_sub} <= dst_nxt;
    end
  end
endmodule

// File: rtl/vec_step_seq_chk.sv
module vec_step_seq_chk #(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              adv,
  input logic              ld,
  input logic [STEP_W-1:0] ld_src_step,
  input logic [SUB_W-1:0]  ld_src_sub,
  input logic [STEP_W-1:0] ld_dst_step,
  input logic [SUB_W-1:0]  ld_dst_sub,
  input logic [SUB_W-1:0]  sub_len,
  input logic              pack,
  input logic              unpack,
  input logic              src_end,
  input logic              dst_end,
  input logic [STEP_W-1:0] src_step,
  input logic [SUB_W-1:0]  src_sub,
  input logic [STEP_W-1:0] dst_step,
  input logic [SUB_W-1:0]  dst_sub
);
  logic go;
  assign go = adv && !ld;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (src_step == '0 && src_sub == '0 && dst_step == '0 && dst_sub == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!adv && !ld) |=> ($stable(src_step) && $stable(src_sub) && $stable(dst_step) && $stable(dst_sub)));

  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    ld |=> (src_step == $past(ld_src_step) && src_sub == $past(ld_src_sub) &&
            dst_step == $past(ld_dst_step) && dst_sub == $past(ld_dst_sub)));

  assert_inner_sub_R4: assert property (@(posedge clk) disable iff (rst)
    (go && !pack && src_sub != sub_len) |=>
      (src_sub == SUB_W'($past(src_sub) + 1'b1) && $stable(src_step)));

  assert_sub_wrap_step_R5: assert property (@(posedge clk) disable iff (rst)
    (go && !pack && src_sub == sub_len && !src_end) |=>
      (src_sub == '0 && src_step == STEP_W'($past(src_step) + 1'b1)));

  assert_sub_wrap_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (go && !pack && src_sub == sub_len && src_end) |=>
      (src_sub == '0 && $stable(src_step)));

  assert_pack_inner_R7: assert property (@(posedge clk) disable iff (rst)
    (go && pack && !src_end) |=>
      (src_step == STEP_W'($past(src_step) + 1'b1) && $stable(src_sub)));

  assert_pack_outer_R8: assert property (@(posedge clk) disable iff (rst)
    (go && pack && src_end && src_sub != sub_len) |=>
      (src_step == '0 && src_sub == SUB_W'($past(src_sub) + 1'b1)));

  assert_pack_outer_end_R9: assert property (@(posedge clk) disable iff (rst)
    (go && pack && src_end && src_sub == sub_len) |=>
      (src_step == '0 && $stable(src_sub)));

  assert_dst_inner_R10: assert property (@(posedge clk) disable iff (rst)
    (go && !unpack && dst_sub != dst_sub_len_c()) |=>
      (dst_sub == SUB_W'($past(dst_sub) + 1'b1) && $stable(dst_step)));

  assert_dst_unpack_R10: assert property (@(posedge clk) disable iff (rst)
    (go && unpack && dst_end) |=> (dst_step == '0));

  function automatic logic [SUB_W-1:0] dst_sub_len_c();
    return sub_len;
  endfunction
endmodule

bind vec_step_seq vec_step_seq_chk #(.STEP_W(STEP_W), .SUB_W(SUB_W)) u_chk (
  .clk(clk), .rst(rst), .adv(adv), .ld(ld),
  .ld_src_step(ld_src_step), .ld_src_sub(ld_src_sub),
  .ld_dst_step(ld_dst_step), .ld_dst_sub(ld_dst_sub),
  .sub_len(sub_len), .pack(pack), .unpack(unpack),
  .src_end(src_end), .dst_end(dst_end),
  .src_step(src_step), .src_sub(src_sub),
  .dst_step(dst_step), .dst_sub(dst_sub)
);

// File: tb/vec_step_seq_tb.sv
module vec_step_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adv = 1'b0, ld = 1'b0;
  logic [6:0] ld_src_step = '0, ld_dst_step = '0;
  logic [1:0] ld_src_sub = '0, ld_dst_sub = '0;
  logic [1:0] sub_len = 2'd3;
  logic       pack = 1'b0, unpack = 1'b0, src_end = 1'b0, dst_end = 1'b0;
  logic [6:0] src_step, dst_step;
  logic [1:0] src_sub, dst_sub;

  typedef struct {
    logic [6:0] ss;
    logic [1:0] sb;
    logic [6:0] ds;
    logic [1:0] db;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  vec_step_seq u_dut (
    .clk(clk), .rst(rst), .adv(adv), .ld(ld),
    .ld_src_step(ld_src_step), .ld_src_sub(ld_src_sub),
    .ld_dst_step(ld_dst_step), .ld_dst_sub(ld_dst_sub),
    .sub_len(sub_len), .pack(pack), .unpack(unpack),
    .src_end(src_end), .dst_end(dst_end),
    .src_step(src_step), .src_sub(src_sub),
    .dst_step(dst_step), .dst_sub(dst_sub)
  );

  task automatic cyc(input logic r, input logic a, input logic l,
                     input logic p, input logic u, input logic se, input logic de,
                     input logic [1:0] len,
                     input logic [6:0] ess, input logic [1:0] esb,
                     input logic [6:0] eds, input logic [1:0] edb,
                     input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; adv = a; ld = l; pack = p; unpack = u;
    src_end = se; dst_end = de; sub_len = len;
    e.ss = ess; e.sb = esb; e.ds = eds; e.db = edb; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic setld(input logic [6:0] s, input logic [1:0] sb,
                       input logic [6:0] d, input logic [1:0] db);
    ld_src_step = s; ld_src_sub = sb; ld_dst_step = d; ld_dst_sub = db;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (src_step !== e.ss || src_sub !== e.sb || dst_step !== e.ds || dst_sub !== e.db) begin
          fails++;
          $display("FAIL %s: got %0d/%0d %0d/%0d expected %0d/%0d %0d/%0d",
                   e.tag, src_step, src_sub, dst_step, dst_sub, e.ss, e.sb, e.ds, e.db);
        end
      end
    end
  end

  initial begin : driver
    //  r a l p u se de len   expected src step/sub, dst step/sub
    cyc(1,0,0,0,0,0,0,3, 0,0,0,0, "R1 reset");
    cyc(0,0,0,0,0,0,0,3, 0,0,0,0, "R2 idle after reset");
    setld(7'd5, 2'd1, 7'd9, 2'd2);
    cyc(0,1,1,0,0,0,0,3, 5,1,9,2, "R3 load over advance");
    cyc(0,1,0,0,0,0,0,3, 5,2,9,3, "R4 inner sub increments");
    cyc(0,1,0,0,0,0,0,3, 5,3,10,0, "R5 R10 dst sub end bumps step");
    cyc(0,1,0,0,0,1,0,3, 5,0,10,1, "R6 src end holds step");
    cyc(0,0,0,1,1,1,1,1, 5,0,10,1, "R2 controls ignored when idle");
    cyc(0,1,0,1,0,0,1,3, 6,0,10,2, "R7 R10 pack inner step, dst independent");
    cyc(0,1,0,1,1,1,0,3, 0,1,11,2, "R8 R10 pack outer sub, unpack inner step");
    setld(7'd40, 2'd3, 7'd20, 2'd3);
    cyc(0,0,1,0,0,0,0,3, 40,3,20,3, "R3 load");
    cyc(0,1,0,1,1,1,1,3, 0,3,0,3, "R9 R10 both at end");
    setld(7'd0, 2'd0, 7'd0, 2'd1);
    cyc(0,0,1,0,0,0,0,1, 0,0,0,1, "R3 load");
    cyc(0,1,0,0,0,0,0,1, 0,1,1,0, "R4 R5 length one");
    setld(7'd127, 2'd0, 7'd127, 2'd2);
    cyc(0,0,1,0,0,0,0,2, 127,0,127,2, "R3 load max");
    cyc(0,1,0,1,0,0,0,2, 0,0,0,0, "R11 step wraps");
    setld(7'd3, 2'd1, 7'd4, 2'd2);
    cyc(0,0,1,0,0,0,0,3, 3,1,4,2, "R3 load");
    cyc(1,1,1,0,0,0,0,3, 0,0,0,0, "R1 reset over load and advance");
    cyc(0,0,0,0,0,0,0,3, 0,0,0,0, "R2 idle");
    @(negedge clk);
    adv = 1'b0; ld = 1'b0;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin : watchdog
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected done");
    end
    done = 1'b1;
  end

  initial begin
    wait (done);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule